// File: doc/BRIEF.md
# Flash Command Controller with Coefficient Copy

This block is the device-side controller for a small on-chip flash array of 16-bit words, arranged as pages of words. Software reaches it through a simple register bus with four registers: a mode register that takes command bytes, an address register holding a page field and a word field, a data-in register and a read-only data-out register. Writing a command byte to the mode register starts one of five operations: erase the whole array, erase one page, write one word, read one word, or copy the whole flash into a paired coefficient RAM.

While an operation runs, bit 0 of the mode register reads 1, and software polls it until it clears. Each operation lasts a fixed number of clock cycles set by a parameter, so a testbench can shrink the real millisecond-scale timings. When a conversion-running input is high, or while busy, command writes are dropped. The flash array and coefficient RAM are behavioural register arrays inside the block. The coefficient RAM can be read through a dedicated port.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the mode, address, data-in and data-out registers read 0000h, every flash word is FFFFh and every coefficient RAM word is 0000h.
- R2: Register offsets are 18h mode, 19h address, 1Ah data-in, 1Bh data-out; 19h and 1Ah read back what was written, a write to 1Bh has no effect, and other offsets read 0000h.
- R3: The mode register reads {8'h00, last accepted command bits 7:1, busy}. An accepted command makes busy read 1 from the next cycle for exactly the operation's cycle count (mass erase MASS_CYC, page erase PAGE_CYC, word write WRITE_CYC, word read READ_CYC, copy XFER_CYC).
- R4: A command write while the conversion-running input is high is dropped: busy stays 0 and no operation takes place.
- R5: A command write while busy, or with a byte other than 60h, 40h, 20h, A0h or C0h, is dropped and leaves busy and the reported last command unchanged.
- R6: Command 20h ANDs the data-in value into the flash word at index page*2^WORD_BITS+word, where page is address bits [8 +: PAGE_BITS] and word is address bits [WORD_BITS-1:0], so a write can only clear bits.
- R7: Command A0h loads the addressed flash word into the data-out register in the cycle busy clears.
- R8: Command 40h sets every word of the addressed page to FFFFh and leaves other pages unchanged.
- R9: Command 60h sets every flash word to FFFFh.
- R10: Command C0h sets coefficient RAM word N to {flash[2N+1][7:0], flash[2N][7:0]} for every N.
- R11: The address and data-in values are captured when a command is accepted; writes to those registers during the operation do not change its target or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_run | input | 1 | Conversion running; blocks new commands when high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 16 | Register write data |
| rd_sel | input | 8 | Register read offset |
| reg_rdata | output | 16 | Register read data (combinational) |
| coef_addr | input | PAGE_BITS+WORD_BITS-1 | Coefficient RAM read address |
| coef_rdata | output | 16 | Coefficient RAM read data |

## Verification
Word writes are tried first on an erased cell and then over a written one with a pattern that overlaps it, which separates an AND merge from a plain overwrite. Page erase is run with data placed in the target page and in a neighbour, so an erase that ignores the page field or clears too much shows up, while mass erase is run after several pages hold data. Commands are issued while busy, while the conversion input is high, with an unknown byte, and with the address changed mid-operation; each of these must leave the array and the reported last command as a model predicts. The copy is run with different low bytes in the even and odd source words, so swapped byte halves are told apart, and every register read and the coefficient port are compared with the model on each clock.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  localparam logic [7:0] REG_MODE = 8'h18;
  localparam logic [7:0] REG_ADDR = 8'h19;
  localparam logic [7:0] REG_DIN  = 8'h1A;
  localparam logic [7:0] REG_DOUT = 8'h1B;

  localparam logic [15:0] ERASED_WORD = 16'hFFFF;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MASS  = 3'd1,
    OP_PAGE  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4,
    OP_XFER  = 3'd5
  } op_e;

  // Command byte to operation; anything unknown maps to OP_NONE.
  function automatic op_e decode_cmd(input logic [7:0] b);
    case (b)
      8'h60:   return OP_MASS;
      8'h40:   return OP_PAGE;
      8'h20:   return OP_WRITE;
      8'hA0:   return OP_READ;
      8'hC0:   return OP_XFER;
      default: return OP_NONE;
    endcase
  endfunction

  // A program step can only pull bits low.
  function automatic logic [15:0] merge_write(input logic [15:0] old_w,
                                              input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  // Coefficient word from an even/odd flash pair: odd low byte on top.
  function automatic logic [15:0] pack_coef(input logic [15:0] even_w,
                                            input logic [15:0] odd_w);
    return {odd_w[7:0], even_w[7:0]};
  endfunction

endpackage

// File: rtl/flash_reg_if.sv
module flash_reg_if
  import flash_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [7:0]  rd_addr,
  input  logic        busy,
  input  logic [6:0]  last_hi,
  input  logic        load_dout,
  input  logic [15:0] dout_val,
  output logic        mode_stb,
  output logic [7:0]  cmd_byte,
  output logic [15:0] addr_q,
  output logic [15:0] din_q,
  output logic [15:0] dout_q,
  output logic [15:0] rd_data
);

  assign mode_stb = wr_en && (wr_addr == REG_MODE);
  assign cmd_byte = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_ADDR) addr_q <= wr_data;
      if (wr_addr == REG_DIN)  din_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         dout_q <= '0;
    else if (load_dout) dout_q <= dout_val;
  end

  always_comb begin
    case (rd_addr)
      REG_MODE: rd_data = {8'h00, last_hi, busy};
      REG_ADDR: rd_data = addr_q;
      REG_DIN:  rd_data = din_q;
      REG_DOUT: rd_data = dout_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_ctrl_pkg::*;
#(
  parameter int FA_W      = 7,
  parameter int MASS_CYC  = 48,
  parameter int PAGE_CYC  = 24,
  parameter int WRITE_CYC = 10,
  parameter int READ_CYC  = 3,
  parameter int XFER_CYC  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_stb,
  input  logic [7:0]      cmd_byte,
  input  logic            conv_run,
  input  logic [FA_W-1:0] sel_idx,
  input  logic [15:0]     din,
  output logic            busy,
  output op_e             op_kind,
  output logic [FA_W-1:0] op_idx,
  output logic [15:0]     op_data,
  output logic [6:0]      last_hi,
  output logic            cmd_accept,
  output logic            op_done
);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CYC = max2(max2(max2(MASS_CYC, PAGE_CYC), max2(WRITE_CYC, READ_CYC)), XFER_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  function automatic logic [CNT_W-1:0] dur_of(input op_e k);
    case (k)
      OP_MASS:  return CNT_W'(MASS_CYC);
      OP_PAGE:  return CNT_W'(PAGE_CYC);
      OP_WRITE: return CNT_W'(WRITE_CYC);
      OP_READ:  return CNT_W'(READ_CYC);
      OP_XFER:  return CNT_W'(XFER_CYC);
      default:  return CNT_W'(1);
    endcase
  endfunction

  op_e             req_op;
  logic [CNT_W-1:0] cnt_q;

  assign req_op     = decode_cmd(cmd_byte);
  assign cmd_accept = mode_stb && !busy && !conv_run && (req_op != OP_NONE);
  assign op_done    = busy && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      op_kind <= OP_NONE;
      op_idx  <= '0;
      op_data <= '0;
      last_hi <= '0;
    end else if (cmd_accept) begin
      busy    <= 1'b1;
      cnt_q   <= dur_of(req_op);
      op_kind <= req_op;
      op_idx  <= sel_idx;
      op_data <= din;
      last_hi <= cmd_byte[7:1];
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (op_done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_ctrl_pkg::*;
#(
  parameter int PAGE_BITS = 3,
  parameter int WORD_BITS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           op_done,
  input  op_e                            op_kind,
  input  logic [PAGE_BITS+WORD_BITS-1:0] op_idx,
  input  logic [15:0]                    op_data,
  input  logic [PAGE_BITS+WORD_BITS-2:0] coef_addr,
  output logic [15:0]                    hit_word,
  output logic [15:0]                    coef_rdata
);

  localparam int FA_W        = PAGE_BITS + WORD_BITS;
  localparam int FLASH_WORDS = 1 << FA_W;
  localparam int COEF_WORDS  = FLASH_WORDS / 2;

  logic [15:0]          cells [FLASH_WORDS];
  logic [15:0]          coef  [COEF_WORDS];
  logic [PAGE_BITS-1:0] op_page;

  assign op_page = op_idx[FA_W-1 -: PAGE_BITS];

  for (genvar i = 0; i < FLASH_WORDS; i++) begin : g_cell
    localparam logic [PAGE_BITS-1:0] MY_PAGE = PAGE_BITS'(i >> WORD_BITS);
    localparam logic [FA_W-1:0]      MY_IDX  = FA_W'(i);
    logic [15:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cell_q <= ERASED_WORD;
      end else if (op_done) begin
        case (op_kind)
          OP_MASS:  cell_q <= ERASED_WORD;
          OP_PAGE:  if (op_page == MY_PAGE) cell_q <= ERASED_WORD;
          OP_WRITE: if (op_idx == MY_IDX) cell_q <= merge_write(cell_q, op_data);
          default:  ;
        endcase
      end
    end
    assign cells[i] = cell_q;
  end

  for (genvar n = 0; n < COEF_WORDS; n++) begin : g_coef
    logic [15:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            word_q <= '0;
      else if (op_done && op_kind == OP_XFER) word_q <= pack_coef(cells[2*n], cells[2*n+1]);
    end
    assign coef[n] = word_q;
  end

  assign hit_word   = cells[op_idx];
  assign coef_rdata = coef[coef_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int PAGE_BITS = 3,
  parameter int WORD_BITS = 4,
  parameter int MASS_CYC  = 48,
  parameter int PAGE_CYC  = 24,
  parameter int WRITE_CYC = 10,
  parameter int READ_CYC  = 3,
  parameter int XFER_CYC  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           conv_run,
  input  logic                           reg_wr,
  input  logic [7:0]                     reg_addr,
  input  logic [15:0]                    reg_wdata,
  input  logic [7:0]                     rd_sel,
  output logic [15:0]                    reg_rdata,
  input  logic [PAGE_BITS+WORD_BITS-2:0] coef_addr,
  output logic [15:0]                    coef_rdata
);

  localparam int FA_W = PAGE_BITS + WORD_BITS;

  // Named internal events, observed by the bound checker.
  logic            mode_stb;
  logic [7:0]      cmd_byte;
  logic [15:0]     addr_q;
  logic [15:0]     din_q;
  logic [15:0]     dout_q;
  logic            busy;
  op_e             op_kind;
  logic [FA_W-1:0] sel_idx;
  logic [FA_W-1:0] op_idx;
  logic [15:0]     op_data;
  logic [6:0]      last_hi;
  logic            cmd_accept;
  logic            op_done;
  logic            read_done;
  logic [15:0]     hit_word;

  assign sel_idx   = {addr_q[8 +: PAGE_BITS], addr_q[WORD_BITS-1:0]};
  assign read_done = op_done && (op_kind == OP_READ);

  flash_reg_if u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wr_addr   (reg_addr),
    .wr_data   (reg_wdata),
    .rd_addr   (rd_sel),
    .busy      (busy),
    .last_hi   (last_hi),
    .load_dout (read_done),
    .dout_val  (hit_word),
    .mode_stb  (mode_stb),
    .cmd_byte  (cmd_byte),
    .addr_q    (addr_q),
    .din_q     (din_q),
    .dout_q    (dout_q),
    .rd_data   (reg_rdata)
  );

  flash_op_seq #(
    .FA_W      (FA_W),
    .MASS_CYC  (MASS_CYC),
    .PAGE_CYC  (PAGE_CYC),
    .WRITE_CYC (WRITE_CYC),
    .READ_CYC  (READ_CYC),
    .XFER_CYC  (XFER_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_stb   (mode_stb),
    .cmd_byte   (cmd_byte),
    .conv_run   (conv_run),
    .sel_idx    (sel_idx),
    .din        (din_q),
    .busy       (busy),
    .op_kind    (op_kind),
    .op_idx     (op_idx),
    .op_data    (op_data),
    .last_hi    (last_hi),
    .cmd_accept (cmd_accept),
    .op_done    (op_done)
  );

  flash_store #(
    .PAGE_BITS (PAGE_BITS),
    .WORD_BITS (WORD_BITS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_done    (op_done),
    .op_kind    (op_kind),
    .op_idx     (op_idx),
    .op_data    (op_data),
    .coef_addr  (coef_addr),
    .hit_word   (hit_word),
    .coef_rdata (coef_rdata)
  );

endmodule

// File: rtl/flash_ctrl_checks.sv
module flash_ctrl_checks
  import flash_ctrl_pkg::*;
#(
  parameter int MAX_CYC = 48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_run,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [7:0]  cmd_lo,
  input logic        busy,
  input logic        cmd_accept,
  input logic        op_done,
  input op_e         op_kind,
  input logic [15:0] dout_q,
  input logic [15:0] hit_word
);

  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R3: busy only rises after an accepted command
  p_launch_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_accept));

  // R3: completion drops busy on the next cycle
  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy);

  // R3: no operation outlasts the longest configured duration
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < MAX_CYC));

  // R4: conversion running blocks a launch from idle
  p_conv_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_MODE && conv_run && !busy) |=> !busy);

  // R5: an operation is never cut short by a new write
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

  // R5: unknown command bytes never start anything
  p_unknown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_MODE && decode_cmd(cmd_lo) == OP_NONE && !busy) |=> !busy);

  // R7: read completion loads the addressed word
  p_dout_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_kind == OP_READ) |=> (dout_q == $past(hit_word)));

  // R7: data-out changes only on read completion
  p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && op_kind == OP_READ) |=> $stable(dout_q));

endmodule

bind flash_cmd_ctrl flash_ctrl_checks #(
  .MAX_CYC (MASS_CYC > XFER_CYC ? (MASS_CYC > PAGE_CYC ? MASS_CYC : PAGE_CYC) : (XFER_CYC > PAGE_CYC ? XFER_CYC : PAGE_CYC))
) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_run   (conv_run),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .cmd_lo     (reg_wdata[7:0]),
  .busy       (busy),
  .cmd_accept (cmd_accept),
  .op_done    (op_done),
  .op_kind    (op_kind),
  .dout_q     (dout_q),
  .hit_word   (hit_word)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PB = 3;
  localparam int WB = 4;
  localparam int NWORDS = 1 << (PB + WB);
  localparam int NCOEF = NWORDS / 2;
  localparam int C_MASS = 48, C_PAGE = 24, C_WRITE = 10, C_READ = 3, C_XFER = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        conv_run = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [7:0]  rd_sel = 8'h18;
  logic [15:0] reg_rdata;
  logic [PB+WB-2:0] coef_addr = 0;
  logic [15:0] coef_rdata;

  flash_cmd_ctrl #(.PAGE_BITS(PB), .WORD_BITS(WB), .MASS_CYC(C_MASS), .PAGE_CYC(C_PAGE),
                   .WRITE_CYC(C_WRITE), .READ_CYC(C_READ), .XFER_CYC(C_XFER)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_run(conv_run), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_sel(rd_sel), .reg_rdata(reg_rdata),
    .coef_addr(coef_addr), .coef_rdata(coef_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit started = 0;

  // ---------------- behavioural reference model ----------------
  int m_flash [NWORDS];
  int m_coef [NCOEF];
  int m_busy, m_cnt, m_cmd, m_addr, m_din, m_dout, m_last, m_sa, m_sd;

  function automatic int dur_for(int c);
    if (c == 'h60) return C_MASS;
    if (c == 'h40) return C_PAGE;
    if (c == 'h20) return C_WRITE;
    if (c == 'hA0) return C_READ;
    return C_XFER;
  endfunction

  function automatic bit known(int c);
    return c == 'h60 || c == 'h40 || c == 'h20 || c == 'hA0 || c == 'hC0;
  endfunction

  function automatic int flat_index(int a);
    return ((a >> 8) % (1 << PB)) * (1 << WB) + (a % (1 << WB));
  endfunction

  task automatic model_finish();
    int idx = flat_index(m_sa);
    case (m_cmd)
      'h60: foreach (m_flash[k]) m_flash[k] = 'hFFFF;
      'h40: foreach (m_flash[k]) if (k / (1 << WB) == idx / (1 << WB)) m_flash[k] = 'hFFFF;
      'h20: m_flash[idx] = m_flash[idx] & m_sd;
      'hA0: m_dout = m_flash[idx];
      default: foreach (m_coef[n]) m_coef[n] = ((m_flash[2*n+1] % 256) * 256) + (m_flash[2*n] % 256);
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_flash[k]) m_flash[k] = 'hFFFF;
      foreach (m_coef[k]) m_coef[k] = 0;
      m_busy = 0; m_cnt = 0; m_cmd = 0; m_addr = 0; m_din = 0; m_dout = 0; m_last = 0;
      m_sa = 0; m_sd = 0;
    end else begin
      int was_busy;
      was_busy = m_busy;
      if (m_busy != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          model_finish();
          m_busy = 0;
        end
      end
      if (reg_wr) begin
        if (reg_addr == 8'h19) m_addr = reg_wdata;
        else if (reg_addr == 8'h1A) m_din = reg_wdata;
        else if (reg_addr == 8'h18 && was_busy == 0 && !conv_run && known(reg_wdata[7:0])) begin
          m_busy = 1; m_cmd = reg_wdata[7:0]; m_cnt = dur_for(m_cmd);
          m_sa = m_addr; m_sd = m_din; m_last = m_cmd;
        end
      end
    end
  end

  function automatic int exp_reg(logic [7:0] s);
    case (s)
      8'h18: return (m_last & 'hFE) | m_busy;
      8'h19: return m_addr;
      8'h1A: return m_din;
      8'h1B: return m_dout;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare every register read and the coefficient port with the model on each clock.
  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      #2;
      check("R3 per-cycle register read", reg_rdata, 16'(exp_reg(rd_sel)));
      check("R10 per-cycle coefficient read", coef_rdata, 16'(m_coef[coef_addr]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    rd_sel = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int n = 0;
    rd(8'h18, v);
    while (v[0] && n < 5000) begin
      @(negedge clk); rd(8'h18, v); n++;
    end
  endtask

  function automatic logic [15:0] loc(int page, int word);
    return 16'((page << 8) | word);
  endfunction

  task automatic fwrite(int page, int word, logic [15:0] d);
    wr(8'h19, loc(page, word)); wr(8'h1A, d); wr(8'h18, 16'h0020); wait_idle();
  endtask

  task automatic fread(int page, int word, output logic [15:0] v);
    wr(8'h19, loc(page, word)); wr(8'h18, 16'h00A0); wait_idle(); rd(8'h1B, v);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v0;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    started = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h18, v); check("R1 mode after reset", v, 16'h0000);
    rd(8'h19, v); check("R1 address after reset", v, 16'h0000);
    rd(8'h1B, v); check("R1 data-out after reset", v, 16'h0000);
    coef_addr = 5; #1; check("R1 coefficient after reset", coef_rdata, 16'h0000);
    fread(5, 0, v); check("R1 R7 erased word read", v, 16'hFFFF);

    // R2 register access
    wr(8'h19, 16'h1234); rd(8'h19, v); check("R2 address readback", v, 16'h1234);
    wr(8'h1A, 16'hABCD); rd(8'h1A, v); check("R2 data-in readback", v, 16'hABCD);
    rd(8'h1B, v0); wr(8'h1B, 16'h5555); rd(8'h1B, v); check("R2 data-out write ignored", v, v0);
    rd(8'h2C, v); check("R2 unused offset", v, 16'h0000);

    // R6 AND-merge word write
    fwrite(2, 3, 16'h12F0); fread(2, 3, v); check("R6 write on erased cell", v, 16'h12F0);
    fwrite(2, 3, 16'hFF0F); fread(2, 3, v); check("R6 overwrite ANDs", v, 16'h1200);

    // R3 busy window and mode contents
    wr(8'h19, loc(4, 1)); wr(8'h1A, 16'h0F00);
    @(negedge clk); reg_wr = 1; reg_addr = 8'h18; reg_wdata = 16'h0020;
    @(negedge clk); reg_wr = 0;
    rd(8'h18, v); check("R3 mode while busy", v, 16'h0021);
    n = 0;
    while (v[0] && n < 1000) begin n++; @(negedge clk); rd(8'h18, v); end
    check("R3 busy cycle count", 16'(n), 16'(C_WRITE));
    check("R3 mode after finish", v, 16'h0020);

    // R4 conversion running
    conv_run = 1;
    wr(8'h19, loc(2, 0)); wr(8'h18, 16'h0040);
    rd(8'h18, v); check("R4 no busy with conversion running", v, 16'h0020);
    conv_run = 0;
    fread(2, 3, v); check("R4 page untouched", v, 16'h1200);

    // R5 commands while busy and unknown bytes
    fwrite(0, 1, 16'h0F0F);
    wr(8'h19, loc(6, 0)); wr(8'h18, 16'h0040); wr(8'h18, 16'h0060); wait_idle();
    rd(8'h18, v); check("R5 last command kept under busy", v, 16'h0040);
    fread(0, 1, v); check("R5 mass erase dropped while busy", v, 16'h0F0F);
    wr(8'h18, 16'h0055); rd(8'h18, v); check("R5 unknown byte ignored", v, 16'h00A0);

    // R8 page erase
    fwrite(1, 2, 16'h1111); fwrite(2, 5, 16'h2222);
    wr(8'h19, loc(2, 0)); wr(8'h18, 16'h0040); wait_idle();
    fread(2, 5, v); check("R8 erased page word", v, 16'hFFFF);
    fread(2, 3, v); check("R8 erased page other word", v, 16'hFFFF);
    fread(1, 2, v); check("R8 neighbour page kept", v, 16'h1111);

    // R11 snapshot at launch
    wr(8'h19, loc(3, 4)); wr(8'h1A, 16'h3C3C); wr(8'h18, 16'h0020);
    wr(8'h19, loc(3, 5)); wr(8'h1A, 16'h0000); wait_idle();
    fread(3, 4, v); check("R11 captured target written", v, 16'h3C3C);
    fread(3, 5, v); check("R11 later address untouched", v, 16'hFFFF);

    // R10 flash to coefficient copy
    fwrite(0, 2, 16'hAB12); fwrite(0, 3, 16'hCD34);
    wr(8'h18, 16'h00C0); wait_idle();
    coef_addr = 1; #1; check("R10 coefficient pair 2/3", coef_rdata, 16'h3412);
    coef_addr = 0; #1; check("R10 coefficient pair 0/1", coef_rdata, 16'h0FFF);
    coef_addr = 7; #1; check("R10 coefficient erased pair", coef_rdata, 16'hFFFF);

    // R9 mass erase
    wr(8'h18, 16'h0060); wait_idle();
    fread(1, 2, v); check("R9 mass erase page 1", v, 16'hFFFF);
    fread(0, 1, v); check("R9 mass erase page 0", v, 16'hFFFF);
    fread(7, 15, v); check("R9 mass erase last word", v, 16'hFFFF);
    coef_addr = 1; #1; check("R9 coefficient RAM kept", coef_rdata, 16'h3412);

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule